// File: doc/BRIEF.md
# Peripheral DMA Request Front End

This block sits between the handshake pins of external peripherals and the per-channel DMA engine. For every channel it converts the raw request pin into a clean internal request and drives the acknowledge pin and the end-of-transfer pin. The active level of each of these three pins is chosen per channel.

The incoming request is synchronized asymmetrically. A rising request must be seen at two consecutive clock edges before the engine sees it, which protects against metastability. A falling request is passed on after a single edge, so the engine stops requesting promptly. The internal request is masked by the channel-enable input.

The block also tells the engine when a channel may start: the channel is enabled and its terminal-count, end-of-transfer and error status flags are all clear. Polarity settings can be written only while the channel is disabled. Writes made while the channel is enabled are dropped, so the pins cannot glitch during a transfer. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `dma_req_frontend`

## Requirements
- R1: After reset, the polarity of every channel is active-high for request, acknowledge and end-of-transfer, and `req_o`, `ack_pin_o` and `eot_pin_o` are 0.
- R2: A polarity write (`pol_wr_i[c]`=1) sampled at a clock edge while `ch_en_i[c]`=0 loads `pol_wdata_i` into channel c, and the new levels apply after that edge. A write sampled while `ch_en_i[c]`=1 is ignored and the previous polarity stays in force.
- R3: `req_o[c]` goes to 1 only after the request pin has been sampled at its active level on two consecutive rising edges. It rises right after the second such edge, so a request that is active at only one edge never reaches `req_o`.
- R4: `req_o[c]` drops to 0 right after the first rising edge that samples the request pin at its inactive level.
- R5: Polarity bit 0 selects the request level: 1 means a high pin is an active request, and 0 means a low pin is an active request.
- R6: `req_o[c]` is the synchronized request ANDed combinationally with `ch_en_i[c]`. Clearing the enable removes the request in the same cycle, and setting it again restores the request without resynchronizing.
- R7: Polarity bit 1 sets the acknowledge level. `ack_pin_o[c]` equals bit 1 while `core_ack_i[c]`=1 and equals its inverse otherwise, combinationally.
- R8: Polarity bit 2 sets the end-of-transfer level. `eot_pin_o[c]` equals bit 2 while `core_eot_i[c]`=1 and equals its inverse otherwise, combinationally.
- R9: `start_ok_o[c]` is 1 exactly when `ch_en_i[c]`=1 and `stat_tc_i[c]`, `stat_eot_i[c]` and `stat_err_i[c]` are all 0, combinationally.
- R10: While the internal reset is active, the acknowledge and end-of-transfer pins stay at their inactive level whatever the engine drives. The internal reset ends after the second rising edge following the release of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin_i | input | NUM_CH | Raw peripheral request pins |
| ch_en_i | input | NUM_CH | Per-channel enable |
| pol_wr_i | input | NUM_CH | Per-channel polarity write strobe |
| pol_wdata_i | input | 3 | Polarity data: bit 0 request, bit 1 acknowledge, bit 2 end-of-transfer (1 = active-high) |
| core_ack_i | input | NUM_CH | Acknowledge from the channel engine |
| core_eot_i | input | NUM_CH | End-of-transfer / terminal count from the engine |
| stat_tc_i | input | NUM_CH | Terminal-count status flag |
| stat_eot_i | input | NUM_CH | End-of-transfer status flag |
| stat_err_i | input | NUM_CH | Error status flag |
| req_o | output | NUM_CH | Clean internal request to the engine |
| start_ok_o | output | NUM_CH | Channel is allowed to start |
| ack_pin_o | output | NUM_CH | Physical acknowledge pin |
| eot_pin_o | output | NUM_CH | Physical end-of-transfer pin |

## Verification
The results are due at different times. A rising request reaches `req_o` after the second edge that samples it, and a falling request after the first. A polarity write takes effect after one edge, and the internal reset ends two edges after `rst_n` rises. The pin outputs and the start gate follow their inputs in the same cycle. The bench therefore drives every input on the falling edge. It checks registered results on the next falling edge, after a history model has been advanced once per rising edge. It checks combinational results a short delay after the drive. The request sweep covers every six-cycle pin pattern for both polarities on each channel.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  // Per-channel pin levels: 1 = active-high, 0 = active-low.
  typedef struct packed {
    logic eot_hi;
    logic ack_hi;
    logic req_hi;
  } pin_pol_t;

  localparam int POL_W = $bits(pin_pol_t);
  localparam pin_pol_t POL_RESET = pin_pol_t'({POL_W{1'b1}});
endpackage

// File: rtl/dma_fe_rst_sync.sv
module dma_fe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dma_fe_req_sync.sv
module dma_fe_req_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,   // polarity-corrected request, 1 = active
  output logic seen_o
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = level_i;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  // Rise needs both stages; fall is taken from the first stage alone.
  assign seen_o = s1_q & s2_q;

  p_two_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_o |-> ($past(level_i) && $past(level_i, 2)));

  p_one_edge_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(level_i) |-> !seen_o);
endmodule

// File: rtl/dma_fe_chan.sv
module dma_fe_chan
  import dma_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_pin_i,
  input  logic     ch_en_i,
  input  logic     pol_wr_i,
  input  pin_pol_t pol_wdata_i,
  input  logic     core_ack_i,
  input  logic     core_eot_i,
  input  logic     stat_tc_i,
  input  logic     stat_eot_i,
  input  logic     stat_err_i,
  output logic     req_o,
  output logic     start_ok_o,
  output logic     ack_pin_o,
  output logic     eot_pin_o
);
  pin_pol_t pol_q, pol_d;
  logic     pol_we;
  logic     req_level;
  logic     req_seen;
  logic     ack_act, eot_act;

  // Polarity register: writes accepted only while the channel is idle.
  always_comb begin
    pol_we = pol_wr_i & ~ch_en_i;
    pol_d  = pol_we ? pol_wdata_i : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= POL_RESET;
    else        pol_q <= pol_d;
  end

  p_pol_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ch_en_i) |-> $stable(pol_q));

  // Request path.
  assign req_level = ~(req_pin_i ^ pol_q.req_hi);

  dma_fe_req_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (req_level),
    .seen_o  (req_seen)
  );

  assign req_o = req_seen & ch_en_i;

  // Start gate.
  assign start_ok_o = ch_en_i & ~(stat_tc_i | stat_eot_i | stat_err_i);

  // Output pins: inactive while the internal reset is held.
  assign ack_act   = core_ack_i & rst_n;
  assign eot_act   = core_eot_i & rst_n;
  assign ack_pin_o = ~(ack_act ^ pol_q.ack_hi);
  assign eot_pin_o = ~(eot_act ^ pol_q.eot_hi);

  p_ack_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(core_ack_i) && $stable(pol_q)) |-> $stable(ack_pin_o));

  p_eot_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(core_eot_i) && $stable(pol_q)) |-> $stable(eot_pin_o));
endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend
  import dma_fe_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_pin_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] pol_wr_i,
  input  logic [POL_W-1:0]  pol_wdata_i,
  input  logic [NUM_CH-1:0] core_ack_i,
  input  logic [NUM_CH-1:0] core_eot_i,
  input  logic [NUM_CH-1:0] stat_tc_i,
  input  logic [NUM_CH-1:0] stat_eot_i,
  input  logic [NUM_CH-1:0] stat_err_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] start_ok_o,
  output logic [NUM_CH-1:0] ack_pin_o,
  output logic [NUM_CH-1:0] eot_pin_o
);
  logic     rst_int_n;
  pin_pol_t pol_wdata;

  assign pol_wdata = pin_pol_t'(pol_wdata_i);

  dma_fe_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_fe_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .req_pin_i   (req_pin_i[c]),
      .ch_en_i     (ch_en_i[c]),
      .pol_wr_i    (pol_wr_i[c]),
      .pol_wdata_i (pol_wdata),
      .core_ack_i  (core_ack_i[c]),
      .core_eot_i  (core_eot_i[c]),
      .stat_tc_i   (stat_tc_i[c]),
      .stat_eot_i  (stat_eot_i[c]),
      .stat_err_i  (stat_err_i[c]),
      .req_o       (req_o[c]),
      .start_ok_o  (start_ok_o[c]),
      .ack_pin_o   (ack_pin_o[c]),
      .eot_pin_o   (eot_pin_o[c])
    );
  end
endmodule

// File: tb/dma_req_frontend_tb_top.sv
module dma_req_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req_pin, ch_en, pol_wr, core_ack, core_eot, st_tc, st_eot, st_err;
  logic [2:0]     pol_wdata;
  logic [NCH-1:0] req_o, start_ok, ack_pin, eot_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_frontend #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_pin_i(req_pin), .ch_en_i(ch_en),
    .pol_wr_i(pol_wr), .pol_wdata_i(pol_wdata), .core_ack_i(core_ack),
    .core_eot_i(core_eot), .stat_tc_i(st_tc), .stat_eot_i(st_eot),
    .stat_err_i(st_err), .req_o(req_o), .start_ok_o(start_ok),
    .ack_pin_o(ack_pin), .eot_pin_o(eot_pin)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic next_neg();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_pol(input int c, input logic [2:0] v);
    pol_wr[c] = 1'b1;
    pol_wdata = v;
    next_neg();
    pol_wr[c] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_pin = '0; ch_en = '0; pol_wr = '0; pol_wdata = '0;
    core_ack = '1; core_eot = '1; st_tc = '0; st_eot = '0; st_err = '0;
    repeat (3) @(negedge clk);
    // R1 / R10: outputs inactive under reset even with engine driving
    for (int c = 0; c < NCH; c++) begin
      chk("R10 ack in reset", ack_pin[c], 1'b0);
      chk("R10 eot in reset", eot_pin[c], 1'b0);
      chk("R1 req in reset", req_o[c], 1'b0);
    end
    rst_n = 1'b1;
    next_neg();
    chk("R10 still held after 1 edge", ack_pin[0], 1'b0);
    next_neg();
    chk("R10 released after 2 edges ack", ack_pin[0], 1'b1);
    chk("R10 released after 2 edges eot", eot_pin[1], 1'b1);
    core_ack = '0; core_eot = '0;
    #1;
    chk("R1 default ack inactive low", ack_pin[0], 1'b0);
    chk("R1 default eot inactive low", eot_pin[1], 1'b0);
    // R1 default request active-high
    ch_en[0] = 1'b1; req_pin[0] = 1'b1;
    next_neg(); next_neg();
    chk("R1 default req active-high", req_o[0], 1'b1);
    req_pin[0] = 1'b0;
    next_neg();
    chk("R4 drop after one edge", req_o[0], 1'b0);
    ch_en = '0;

    // R3 / R4 / R5 sweep: every six-cycle pattern, both polarities, each channel
    for (int c = 0; c < NCH; c++) begin
      for (int rp = 0; rp < 2; rp++) begin
        ch_en = '0;
        write_pol(c, {2'b11, rp[0]});
        ch_en[c] = 1'b1;
        req_pin[c] = ~rp[0];
        next_neg(); next_neg();
        for (int p = 0; p < 64; p++) begin
          logic h1, h2;
          h1 = 1'b0; h2 = 1'b0;
          req_pin[c] = ~rp[0];
          next_neg(); next_neg();
          chk("R4 idle before pattern", req_o[c], 1'b0);
          for (int k = 0; k < 6; k++) begin
            logic b;
            b = p[k];
            req_pin[c] = rp[0] ? b : ~b;
            next_neg();
            h2 = h1; h1 = b;
            chk(rp[0] ? "R3 R4 sweep high" : "R5 R3 R4 sweep low", req_o[c], h1 & h2);
            chk("R6 other channel disabled", req_o[1-c], 1'b0);
          end
        end
        req_pin[c] = ~rp[0];
      end
    end

    // R6: enable masks the synchronized request combinationally
    ch_en = '0;
    write_pol(0, 3'b111);
    ch_en[0] = 1'b1; req_pin[0] = 1'b1;
    next_neg(); next_neg(); next_neg();
    chk("R6 req with enable", req_o[0], 1'b1);
    ch_en[0] = 1'b0; #1;
    chk("R6 enable cleared masks req", req_o[0], 1'b0);
    ch_en[0] = 1'b1; #1;
    chk("R6 enable restored no resync", req_o[0], 1'b1);
    req_pin[0] = 1'b0; ch_en = '0;
    next_neg();

    // R7 / R8 sweep over all polarity and engine combinations
    for (int c = 0; c < NCH; c++) begin
      for (int pv = 0; pv < 8; pv++) begin
        write_pol(c, pv[2:0]);
        for (int e = 0; e < 4; e++) begin
          core_ack[c] = e[0]; core_eot[c] = e[1]; #1;
          chk("R7 ack level", ack_pin[c], e[0] ? pv[1] : ~pv[1]);
          chk("R8 eot level", eot_pin[c], e[1] ? pv[2] : ~pv[2]);
        end
        core_ack[c] = 1'b0; core_eot[c] = 1'b0;
      end
      write_pol(c, 3'b111);
    end

    // R2: polarity locked while enabled
    ch_en[0] = 1'b1;
    write_pol(0, 3'b000);
    #1;
    chk("R2 locked ack polarity", ack_pin[0], 1'b0);
    chk("R2 locked eot polarity", eot_pin[0], 1'b0);
    core_ack[0] = 1'b1; #1;
    chk("R2 locked ack still active-high", ack_pin[0], 1'b1);
    core_ack[0] = 1'b0;
    ch_en[0] = 1'b0;
    write_pol(0, 3'b000);
    #1;
    chk("R2 idle write applies ack", ack_pin[0], 1'b1);
    chk("R2 idle write applies eot", eot_pin[0], 1'b1);

    // R9: start gate, all combinations
    for (int c = 0; c < NCH; c++) begin
      for (int v = 0; v < 16; v++) begin
        ch_en[c] = v[0]; st_tc[c] = v[1]; st_eot[c] = v[2]; st_err[c] = v[3]; #1;
        chk("R9 start gate", start_ok[c], v[0] & ~(v[1] | v[2] | v[3]));
      end
      ch_en[c] = 1'b0; st_tc[c] = 1'b0; st_eot[c] = 1'b0; st_err[c] = 1'b0;
    end

    next_neg();
    finish_run();
  end
endmodule